// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block decides, for every frame header the bus receiver has decoded, whether the frame may enter the receive FIFO. It holds a bank of filters. Each filter is a pair of 32-bit words: a mask word that picks which header fields take part in the compare, and an identifier word that gives the values those fields must have. Besides the 29 identifier bits, both words carry a qualifier for extended-identifier format, a qualifier for FD format, and a valid bit. One filter can therefore admit a whole class of frames, such as every standard-ID frame or every FD frame, and it does not have to list identifiers.

Software programs the bank through a simple word-write port. Each filter occupies an 8-byte slot above a base address, with the mask word first and the identifier word four bytes above it. The receiver presents the header with a one-cycle strobe. One clock later the block returns a decision strobe, an accept flag and the number of the lowest-numbered filter that matched.

Top module: `can_accept_filter_bank`

## Requirements
- R1: After reset every filter is invalid, and `dec_valid`, `dec_accept` and `dec_index` are 0. A header sent before any programming is rejected.
- R2: `dec_valid` is high in exactly the cycle that follows a cycle with `hdr_valid` high, and is low otherwise. `dec_accept` is high only together with `dec_valid`.
- R3: A write with `cfg_addr` = BASE_ADDR + 8n loads the mask word of filter n, and a write with `cfg_addr` = BASE_ADDR + 8n + 4 loads its identifier word (default BASE_ADDR 0x800). A write to an address below BASE_ADDR, at or above BASE_ADDR + 8·N_FILTERS, or with address bits [1:0] not 00 changes no filter.
- R4: A filter takes part only when bit 31 is set in both its mask word and its identifier word. A filter with either bit 31 clear never matches.
- R5: For each identifier bit i in 0..28, mask bit i = 1 requires `hdr_id[i]` to equal identifier-word bit i. Mask bit i = 0 makes that bit a don't-care.
- R6: Mask bit 29 = 1 requires `hdr_ext` to equal identifier-word bit 29. With mask bit 29 = 0 the extended flag is ignored.
- R7: Mask bit 30 = 1 requires `hdr_fd` to equal identifier-word bit 30. With mask bit 30 = 0 the FD flag is ignored.
- R8: A header is accepted when at least one valid filter matches. `dec_index` then gives the lowest-numbered matching filter. On a rejection, and in every cycle without a decision, `dec_index` is 0.
- R9: A header is judged against the bank contents as they stood in its strobe cycle. A filter write in that same cycle applies from the next header on.
- R10: A filter whose mask word is 0xA000_0000 and whose identifier word is 0x8000_0000 accepts every standard-ID frame (`hdr_ext` = 0), whatever its identifier bits and FD flag, and rejects every extended-ID frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Filter word write strobe |
| cfg_addr | input | ADDR_W | Byte address of the word written |
| cfg_wdata | input | 32 | Word written |
| hdr_valid | input | 1 | One-cycle strobe marking a received header |
| hdr_id | input | 29 | Frame identifier (standard IDs in bits 10:0) |
| hdr_ext | input | 1 | Frame uses extended-identifier format |
| hdr_fd | input | 1 | Frame uses FD format |
| dec_valid | output | 1 | Decision strobe, one cycle after `hdr_valid` |
| dec_accept | output | 1 | Frame accepted |
| dec_index | output | IDX_W | Lowest matching filter number, 0 when not accepted |

## Verification
The assertions check the decision timing and the priority encoding on every cycle. A decision must follow each strobe and only a strobe, an accept must point at a filter that was valid and matching in the strobe cycle, and no lower-numbered filter may have matched too. The compare semantics can only be shown by the bench's sweeps: which mask bit selects which header field, the exact address decode, the rejection of stray writes, and the same-cycle write ordering. The bench computes its expected accept and index values arithmetically from the programmed words.

// File: rtl/cafb_pkg.sv
package cafb_pkg;
  localparam int WORD_W    = 32;
  localparam int ID_W      = 29;
  localparam int VALID_BIT = 31;
  localparam int FD_BIT    = 30;
  localparam int EXT_BIT   = 29;
  localparam int CMP_W     = ID_W + 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CMP_W-1:0]  cmp_t;

  function automatic logic filter_hit(input word_t mask_w, input word_t ident_w,
                                      input cmp_t frame);
    logic live;
    live = mask_w[VALID_BIT] & ident_w[VALID_BIT];
    return live && (((frame ^ ident_w[CMP_W-1:0]) & mask_w[CMP_W-1:0]) == '0);
  endfunction
endpackage

// File: rtl/cafb_regs.sv
module cafb_regs
  import cafb_pkg::*;
#(
  parameter int          N      = 8,
  parameter int          ADDR_W = 12,
  parameter logic [31:0] BASE   = 32'h800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wdata,
  output word_t             mask_q  [N],
  output word_t             ident_q [N]
);
  localparam int              WA_W  = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] LO  = BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] HI  = ADDR_W'(BASE + 32'(8 * N));

  logic [WA_W-1:0] woff;
  logic            in_bank;

  // word offset from the bank base; bit 0 picks the identifier word
  assign woff    = addr[ADDR_W-1:2] - LO[ADDR_W-1:2];
  assign in_bank = we && (addr >= LO) && (addr < HI) && (addr[1:0] == 2'b00);

  for (genvar n = 0; n < N; n++) begin : g_slot
    logic sel;
    assign sel = in_bank && (woff[WA_W-1:1] == (WA_W-1)'(n));

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[n]  <= '0;
        ident_q[n] <= '0;
      end else if (sel) begin
        if (woff[0]) ident_q[n] <= wdata;
        else         mask_q[n]  <= wdata;
      end
    end
  end
endmodule

// File: rtl/cafb_match.sv
module cafb_match
  import cafb_pkg::*;
#(
  parameter int N = 8
) (
  input  word_t            mask_q  [N],
  input  word_t            ident_q [N],
  input  logic [ID_W-1:0]  id,
  input  logic             ext,
  input  logic             fd,
  output logic [N-1:0]     hit,
  output logic [N-1:0]     fvalid
);
  cmp_t frame;
  assign frame = {fd, ext, id};

  for (genvar n = 0; n < N; n++) begin : g_cmp
    assign fvalid[n] = mask_q[n][VALID_BIT] & ident_q[n][VALID_BIT];
    assign hit[n]    = filter_hit(mask_q[n], ident_q[n], frame);
  end
endmodule

// File: rtl/cafb_prio.sv
module cafb_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     hit,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  assign any = |hit;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/can_accept_filter_bank.sv
module can_accept_filter_bank
  import cafb_pkg::*;
#(
  parameter int          N_FILTERS = 8,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] BASE_ADDR = 32'h800,
  localparam int         IDX_W     = (N_FILTERS > 1) ? $clog2(N_FILTERS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              hdr_valid,
  input  logic [28:0]       hdr_id,
  input  logic              hdr_ext,
  input  logic              hdr_fd,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [IDX_W-1:0]  dec_index
);
  word_t              mask_w  [N_FILTERS];
  word_t              ident_w [N_FILTERS];
  logic [N_FILTERS-1:0] hit_w;
  logic [N_FILTERS-1:0] fvalid_w;
  logic                 any_w;
  logic [IDX_W-1:0]     idx_w;

  cafb_regs #(.N(N_FILTERS), .ADDR_W(ADDR_W), .BASE(BASE_ADDR)) regs_i (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .mask_q (mask_w),
    .ident_q(ident_w)
  );

  cafb_match #(.N(N_FILTERS)) match_i (
    .mask_q (mask_w),
    .ident_q(ident_w),
    .id     (hdr_id),
    .ext    (hdr_ext),
    .fd     (hdr_fd),
    .hit    (hit_w),
    .fvalid (fvalid_w)
  );

  cafb_prio #(.N(N_FILTERS), .IDX_W(IDX_W)) prio_i (
    .hit(hit_w),
    .any(any_w),
    .idx(idx_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_index  <= '0;
    end else begin
      dec_valid  <= hdr_valid;
      dec_accept <= hdr_valid & any_w;
      dec_index  <= (hdr_valid & any_w) ? idx_w : '0;
    end
  end
endmodule

// File: rtl/cafb_checker.sv
module cafb_checker #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             hdr_valid,
  input logic [N-1:0]     hit,
  input logic [N-1:0]     fvalid,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic [IDX_W-1:0] dec_index
);
  logic [N-1:0] hit_d;
  logic [N-1:0] fvalid_d;
  logic [N-1:0] below;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_d    <= '0;
      fvalid_d <= '0;
    end else begin
      hit_d    <= hit;
      fvalid_d <= fvalid;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) below[i] = (i < int'(dec_index));
  end

  // R1: no decision straight out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dec_valid);

  // R2: decision follows each strobe, and only a strobe
  a_r2_decision_follows: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> dec_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(hdr_valid));
  a_r2_accept_in_decision: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> dec_valid);

  // R4: an accepted index points at a filter that was valid
  a_r4_valid_filter: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> fvalid_d[dec_index]);

  // R8: accept exactly when something matched, lowest index wins
  a_r8_index_hit: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> hit_d[dec_index]);
  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> ((hit_d & below) == '0));
  a_r8_no_lost_match: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && (hit_d != '0)) |-> dec_accept);
  a_r8_idle_index: assert property (@(posedge clk) disable iff (rst)
    !dec_accept |-> (dec_index == '0));
endmodule

bind can_accept_filter_bank cafb_checker #(.N(N_FILTERS), .IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .hdr_valid (hdr_valid),
  .hit       (hit_w),
  .fvalid    (fvalid_w),
  .dec_valid (dec_valid),
  .dec_accept(dec_accept),
  .dec_index (dec_index)
);

// File: tb/can_accept_filter_bank_tb_top.sv
`timescale 1ns/1ps
module can_accept_filter_bank_tb_top;
  localparam int          N     = 8;
  localparam int          AW    = 12;
  localparam logic [31:0] BASE  = 32'h800;
  localparam logic [31:0] VLD   = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          hdr_valid = 1'b0;
  logic [28:0]   hdr_id = '0;
  logic          hdr_ext = 1'b0;
  logic          hdr_fd = 1'b0;
  logic          dec_valid;
  logic          dec_accept;
  logic [2:0]    dec_index;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  can_accept_filter_bank #(.N_FILTERS(N), .ADDR_W(AW), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hdr_valid(hdr_valid), .hdr_id(hdr_id), .hdr_ext(hdr_ext), .hdr_fd(hdr_fd),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_index(dec_index)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  function automatic logic [AW-1:0] mask_addr(input int n);
    return AW'(BASE + 32'(8 * n));
  endfunction

  function automatic logic [AW-1:0] ident_addr(input int n);
    return AW'(BASE + 32'(8 * n + 4));
  endfunction

  task automatic clear_bank();
    for (int n = 0; n < N; n++) begin
      wr(mask_addr(n), 32'h0);
      wr(ident_addr(n), 32'h0);
    end
  endtask

  // strobe one header; outputs are registered, so read them one edge later
  task automatic expect_hdr(input logic [28:0] id, input bit ext, input bit fd,
                            input bit eacc, input int eidx, input string req);
    hdr_valid = 1'b1; hdr_id = id; hdr_ext = ext; hdr_fd = fd;
    @(posedge clk); #1;
    hdr_valid = 1'b0;
    check(dec_valid === 1'b1, {req, " decision strobe"}, 32'(dec_valid), 32'd1);
    check({dec_accept, dec_index} === {eacc, eacc ? 3'(eidx) : 3'd0},
          {req, " accept/index"}, {28'd0, dec_accept, dec_index},
          {28'd0, eacc, eacc ? 3'(eidx) : 3'd0});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [28:0] pat;
    logic [28:0] bitm;
    logic [28:0] id_ok;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state and an unprogrammed bank
    check({dec_valid, dec_accept, dec_index} === 5'd0, "R1 outputs after reset",
          {27'd0, dec_valid, dec_accept, dec_index}, 32'd0);
    expect_hdr(29'h0, 1'b0, 1'b0, 1'b0, 0, "R1 empty bank rejects std");
    expect_hdr(29'h1ABC_DEF, 1'b1, 1'b1, 1'b0, 0, "R1 empty bank rejects ext fd");

    // R2: no strobe, no decision
    @(posedge clk); #1;
    check(dec_valid === 1'b0, "R2 idle cycle has no decision", 32'(dec_valid), 32'd0);

    // R4: both valid bits are required
    wr(mask_addr(2), VLD);
    expect_hdr(29'h55, 1'b0, 1'b0, 1'b0, 0, "R4 mask valid only");
    wr(mask_addr(2), 32'h0);
    wr(ident_addr(2), VLD);
    expect_hdr(29'h55, 1'b0, 1'b0, 1'b0, 0, "R4 ident valid only");
    wr(mask_addr(2), VLD);
    expect_hdr(29'h55, 1'b0, 1'b0, 1'b1, 2, "R4 both valid");
    clear_bank();

    // R3: stray writes leave filter 0 untouched
    wr(ident_addr(0), VLD);
    wr(AW'(BASE - 32'd8), VLD);
    expect_hdr(29'h3, 1'b0, 1'b0, 1'b0, 0, "R3 write below base ignored");
    wr(AW'(BASE + 32'(8 * N)), VLD);
    expect_hdr(29'h3, 1'b0, 1'b0, 1'b0, 0, "R3 write past bank ignored");
    wr(AW'(BASE + 32'd1), VLD);
    expect_hdr(29'h3, 1'b0, 1'b0, 1'b0, 0, "R3 misaligned +1 ignored");
    wr(AW'(BASE + 32'd2), VLD);
    expect_hdr(29'h3, 1'b0, 1'b0, 1'b0, 0, "R3 misaligned +2 ignored");
    wr(mask_addr(0), VLD);
    expect_hdr(29'h3, 1'b0, 1'b0, 1'b1, 0, "R3 aligned mask write takes");
    clear_bank();
    // R3: mask at +0, identifier at +4 for filter 5 (extended-only class)
    wr(mask_addr(5), VLD | 32'h2000_0000);
    wr(ident_addr(5), VLD | 32'h2000_0000);
    expect_hdr(29'h1234, 1'b1, 1'b0, 1'b1, 5, "R3 filter 5 ext frame");
    expect_hdr(29'h1234, 1'b0, 1'b0, 1'b0, 0, "R3 filter 5 std frame");
    clear_bank();

    // R5: each identifier bit, selected alone by the mask
    pat = 29'h0ACE_5A3;
    for (int i = 0; i < 29; i++) begin
      bitm = 29'd1 << i;
      wr(mask_addr(0), VLD | {3'b000, bitm});
      wr(ident_addr(0), VLD | {3'b000, pat});
      id_ok = (pat & bitm) | (~pat & ~bitm);
      expect_hdr(id_ok, i[0], i[1], 1'b1, 0, "R5 selected bit equal");
      expect_hdr(id_ok ^ bitm, i[0], i[1], 1'b0, 0, "R5 selected bit differs");
    end
    clear_bank();

    // R6 R7: qualifier masks against every frame class
    for (int mq = 0; mq < 4; mq++) begin
      for (int iq = 0; iq < 4; iq++) begin
        wr(mask_addr(1), VLD | (32'(mq) << 29));
        wr(ident_addr(1), VLD | (32'(iq) << 29) | 32'h0F0F_0F0);
        for (int f = 0; f < 4; f++) begin
          expect_hdr(29'(f * 977), f[0], f[1], (((f ^ iq) & mq) == 0), 1,
                     (mq[0] ? "R6 ext qualifier" : "R7 fd qualifier"));
        end
      end
    end
    clear_bank();

    // R10: standard-class filter in slot 3
    wr(mask_addr(3), 32'hA000_0000);
    wr(ident_addr(3), 32'h8000_0000);
    for (int s = 0; s < 2048; s++) begin
      expect_hdr(29'(s), 1'b0, s[0], 1'b1, 3, "R10 std id accepted");
    end
    for (int s = 0; s < 16; s++) begin
      expect_hdr(29'(s * 33_554_393), 1'b1, s[0], 1'b0, 0, "R10 ext id rejected");
    end
    clear_bank();

    // R8: every subset of valid accept-all filters
    for (int n = 0; n < N; n++) wr(ident_addr(n), VLD);
    for (int s = 0; s < 256; s++) begin
      int lo;
      lo = 0;
      for (int b = 7; b >= 0; b--) if (s[b]) lo = b;
      for (int n = 0; n < N; n++) wr(mask_addr(n), s[n] ? VLD : 32'h0);
      expect_hdr(29'(s * 4099), s[2], s[5], (s != 0), lo, "R8 lowest match wins");
    end
    clear_bank();

    // R9: a write in the strobe cycle only affects later headers
    wr(ident_addr(4), VLD);
    cfg_we = 1'b1; cfg_addr = mask_addr(4); cfg_wdata = VLD;
    expect_hdr(29'h77, 1'b0, 1'b0, 1'b0, 0, "R9 same-cycle write not seen");
    cfg_we = 1'b0;
    expect_hdr(29'h77, 1'b0, 1'b0, 1'b1, 4, "R9 write seen by next header");
    cfg_we = 1'b1; cfg_addr = mask_addr(4); cfg_wdata = 32'h0;
    expect_hdr(29'h77, 1'b0, 1'b0, 1'b1, 4, "R9 same-cycle clear not seen");
    cfg_we = 1'b0;
    expect_hdr(29'h77, 1'b0, 1'b0, 1'b0, 0, "R9 clear seen by next header");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule